// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the control decoder of a single-cycle processor that runs a small 32-bit load/store instruction set. It takes two fields of the current instruction: the 6-bit primary opcode and the 6-bit function field that R-type instructions use. From these it produces, with no clock, every strobe the datapath needs in that cycle:

- the write-destination choice;
- the register-file write enable;
- the immediate extension mode;
- the second ALU operand choice;
- the data-memory read and write enables;
- the write-back source;
- a 4-bit ALU operation code;
- three control-flow indications: jump, branch-if-equal and branch-if-not-equal.

Internally, a classifier first reduces the two fields to a single instruction class. Two small generators then turn that class into a struct of strobes and into the ALU code. The supported set has 16 instructions:

- six R-type register operations;
- five immediate operations;
- word load and word store;
- two conditional branches;
- an absolute jump.

Any other encoding raises an illegal indication and drives every enable inactive. Outputs that the datapath ignores for a given instruction are driven to 0, so every output is fully determined for every input.

Top module: `instrCtlDecoder`

## Requirements
- R1: With opcode 0x00, function codes 0x20, 0x22, 0x24, 0x25, 0x26 and 0x2A give aluCode 0100 (add), 0101 (subtract), 0001 (and), 0010 (or), 0011 (xor) and 0110 (set-less-than) respectively. Each of them sets rdSelect=1 and regWrEn=1, with immOperand=0, signExt=0 and no memory or flow strobe.
- R2: Opcodes 0x08, 0x0A, 0x0C, 0x0D and 0x0E are immediate operations. They give aluCode 0100, 0110, 0001, 0010 and 0011 respectively, with regWrEn=1, immOperand=1 and rdSelect=0.
- R3: signExt is 1 for opcodes 0x08, 0x0A, 0x23, 0x2B, 0x04 and 0x05. It is 0 for 0x0C, 0x0D and 0x0E, and also 0 for R-type, jump and illegal inputs.
- R4: Opcode 0x23 (load word) sets memRdEn=1, wbFromMem=1, regWrEn=1, immOperand=1 and aluCode 0100. No other input asserts memRdEn or wbFromMem.
- R5: Opcode 0x2B (store word) sets memWrEn=1, immOperand=1, aluCode 0100 and regWrEn=0. No other input asserts memWrEn.
- R6: Opcode 0x04 sets brEqHit=1 and opcode 0x05 sets brNeHit=1. Both use aluCode 0101, immOperand=0 and regWrEn=0, and assert no memory enable.
- R7: Opcode 0x02 (jump) sets jumpHit=1 and drives every other output, aluCode included, to 0.
- R8: Any other opcode, or opcode 0x00 with any other function code, sets illegalOp=1 and drives every other output to 0. Every supported encoding gives illegalOp=0.
- R9: For nonzero opcodes the function field has no effect on any output. At most one of jumpHit, brEqHit, brNeHit and illegalOp is 1 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcodeIn | input | 6 | Primary opcode field of the instruction |
| functIn | input | 6 | Function field, used only when opcode is 0 |
| rdSelect | output | 1 | 1: write destination from Rd field; 0: from Rt field |
| regWrEn | output | 1 | Register file write enable |
| signExt | output | 1 | 1: sign-extend the 16-bit immediate; 0: zero-extend |
| immOperand | output | 1 | 1: second ALU operand is the extended immediate; 0: register bus |
| memRdEn | output | 1 | Data memory read enable |
| memWrEn | output | 1 | Data memory write enable |
| wbFromMem | output | 1 | 1: write-back data from memory; 0: from ALU result |
| aluCode | output | 4 | ALU operation code |
| jumpHit | output | 1 | Absolute jump instruction |
| brEqHit | output | 1 | Branch-if-equal instruction |
| brNeHit | output | 1 | Branch-if-not-equal instruction |
| illegalOp | output | 1 | Encoding outside the supported set |

## Verification
The bound checker evaluates several cross-output rules after every input change:

- memory read and memory write are never asserted together;
- a load always writes back through the adder;
- a store and a branch never write a register;
- an illegal encoding leaves every strobe quiet;
- the flow indications are mutually exclusive;
- the Rd destination appears only with opcode 0.

None of these rules can tell whether a given encoding reaches the right class. The exact value of every output for each of the 64 opcodes, and for each of the 64 function codes under opcode 0, is shown only by the bench's exhaustive sweeps. The same holds for the requirement that the function field is ignored for nonzero opcodes.

// File: rtl/instrCtlPkg.sv
package instrCtlPkg;
  parameter int OP_W  = 6;
  parameter int FN_W  = 6;
  parameter int ALU_W = 4;

  // primary opcodes
  localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'h02;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OPC_BNE   = 6'h05;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'h08;
  localparam logic [OP_W-1:0] OPC_SLTI  = 6'h0A;
  localparam logic [OP_W-1:0] OPC_ANDI  = 6'h0C;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'h0D;
  localparam logic [OP_W-1:0] OPC_XORI  = 6'h0E;
  localparam logic [OP_W-1:0] OPC_LDW   = 6'h23;
  localparam logic [OP_W-1:0] OPC_STW   = 6'h2B;

  // R-type function codes
  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_XOR = 6'h26;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  // ALU operation codes
  localparam logic [ALU_W-1:0] ALU_NONE = 4'b0000;
  localparam logic [ALU_W-1:0] ALU_AND  = 4'b0001;
  localparam logic [ALU_W-1:0] ALU_OR   = 4'b0010;
  localparam logic [ALU_W-1:0] ALU_XOR  = 4'b0011;
  localparam logic [ALU_W-1:0] ALU_ADD  = 4'b0100;
  localparam logic [ALU_W-1:0] ALU_SUB  = 4'b0101;
  localparam logic [ALU_W-1:0] ALU_SLT  = 4'b0110;

  typedef enum logic [4:0] {
    CL_BAD,
    CL_RADD, CL_RSUB, CL_RAND, CL_ROR, CL_RXOR, CL_RSLT,
    CL_IADD, CL_ISLT, CL_IAND, CL_IOR, CL_IXOR,
    CL_LDW, CL_STW, CL_BEQ, CL_BNE, CL_JMP
  } instrClass_e;

  typedef struct packed {
    logic rdSelect;
    logic regWrEn;
    logic signExt;
    logic immOperand;
    logic memRdEn;
    logic memWrEn;
    logic wbFromMem;
    logic jumpHit;
    logic brEqHit;
    logic brNeHit;
    logic illegalOp;
  } ctlStrobes_t;
endpackage

// File: rtl/opClassifier.sv
module opClassifier
  import instrCtlPkg::*;
(
  input  logic [OP_W-1:0] opcodeIn,
  input  logic [FN_W-1:0] functIn,
  output instrClass_e     instrClass
);
  instrClass_e rClass;

  // function field is looked at only under the R-type opcode
  always_comb begin
    case (functIn)
      FN_ADD:  rClass = CL_RADD;
      FN_SUB:  rClass = CL_RSUB;
      FN_AND:  rClass = CL_RAND;
      FN_OR:   rClass = CL_ROR;
      FN_XOR:  rClass = CL_RXOR;
      FN_SLT:  rClass = CL_RSLT;
      default: rClass = CL_BAD;
    endcase
  end

  always_comb begin
    case (opcodeIn)
      OPC_RTYPE: instrClass = rClass;
      OPC_ADDI:  instrClass = CL_IADD;
      OPC_SLTI:  instrClass = CL_ISLT;
      OPC_ANDI:  instrClass = CL_IAND;
      OPC_ORI:   instrClass = CL_IOR;
      OPC_XORI:  instrClass = CL_IXOR;
      OPC_LDW:   instrClass = CL_LDW;
      OPC_STW:   instrClass = CL_STW;
      OPC_BEQ:   instrClass = CL_BEQ;
      OPC_BNE:   instrClass = CL_BNE;
      OPC_JMP:   instrClass = CL_JMP;
      default:   instrClass = CL_BAD;
    endcase
  end
endmodule

// File: rtl/strobeGen.sv
module strobeGen
  import instrCtlPkg::*;
(
  input  instrClass_e instrClass,
  output ctlStrobes_t strobes
);
  always_comb begin
    strobes = '0;  // don't-care outputs settle at 0
    case (instrClass)
      CL_RADD, CL_RSUB, CL_RAND, CL_ROR, CL_RXOR, CL_RSLT: begin
        strobes.rdSelect = 1'b1;
        strobes.regWrEn  = 1'b1;
      end
      CL_IADD, CL_ISLT: begin
        strobes.regWrEn    = 1'b1;
        strobes.signExt    = 1'b1;
        strobes.immOperand = 1'b1;
      end
      CL_IAND, CL_IOR, CL_IXOR: begin
        strobes.regWrEn    = 1'b1;
        strobes.immOperand = 1'b1;
      end
      CL_LDW: begin
        strobes.regWrEn    = 1'b1;
        strobes.signExt    = 1'b1;
        strobes.immOperand = 1'b1;
        strobes.memRdEn    = 1'b1;
        strobes.wbFromMem  = 1'b1;
      end
      CL_STW: begin
        strobes.signExt    = 1'b1;
        strobes.immOperand = 1'b1;
        strobes.memWrEn    = 1'b1;
      end
      CL_BEQ: begin
        strobes.signExt = 1'b1;
        strobes.brEqHit = 1'b1;
      end
      CL_BNE: begin
        strobes.signExt = 1'b1;
        strobes.brNeHit = 1'b1;
      end
      CL_JMP:  strobes.jumpHit   = 1'b1;
      default: strobes.illegalOp = 1'b1;
    endcase
  end
endmodule

// File: rtl/aluCodeGen.sv
module aluCodeGen
  import instrCtlPkg::*;
(
  input  instrClass_e      instrClass,
  output logic [ALU_W-1:0] aluCode
);
  always_comb begin
    case (instrClass)
      CL_RAND, CL_IAND:         aluCode = ALU_AND;
      CL_ROR,  CL_IOR:          aluCode = ALU_OR;
      CL_RXOR, CL_IXOR:         aluCode = ALU_XOR;
      CL_RADD, CL_IADD,
      CL_LDW,  CL_STW:          aluCode = ALU_ADD;
      CL_RSUB, CL_BEQ, CL_BNE:  aluCode = ALU_SUB;
      CL_RSLT, CL_ISLT:         aluCode = ALU_SLT;
      default:                  aluCode = ALU_NONE;
    endcase
  end
endmodule

// File: rtl/instrCtlDecoder.sv
module instrCtlDecoder
  import instrCtlPkg::*;
(
  input  logic [5:0] opcodeIn,
  input  logic [5:0] functIn,
  output logic       rdSelect,
  output logic       regWrEn,
  output logic       signExt,
  output logic       immOperand,
  output logic       memRdEn,
  output logic       memWrEn,
  output logic       wbFromMem,
  output logic [3:0] aluCode,
  output logic       jumpHit,
  output logic       brEqHit,
  output logic       brNeHit,
  output logic       illegalOp
);
  instrClass_e instrClass;
  ctlStrobes_t strobes;

  opClassifier u_cls (
    .opcodeIn  (opcodeIn),
    .functIn   (functIn),
    .instrClass(instrClass)
  );

  strobeGen u_stb (
    .instrClass(instrClass),
    .strobes   (strobes)
  );

  aluCodeGen u_alu (
    .instrClass(instrClass),
    .aluCode   (aluCode)
  );

  assign rdSelect   = strobes.rdSelect;
  assign regWrEn    = strobes.regWrEn;
  assign signExt    = strobes.signExt;
  assign immOperand = strobes.immOperand;
  assign memRdEn    = strobes.memRdEn;
  assign memWrEn    = strobes.memWrEn;
  assign wbFromMem  = strobes.wbFromMem;
  assign jumpHit    = strobes.jumpHit;
  assign brEqHit    = strobes.brEqHit;
  assign brNeHit    = strobes.brNeHit;
  assign illegalOp  = strobes.illegalOp;
endmodule

// File: rtl/instrCtlChecker.sv
module instrCtlChecker (
  input logic [5:0] opcodeIn,
  input logic       rdSelect,
  input logic       regWrEn,
  input logic       signExt,
  input logic       immOperand,
  input logic       memRdEn,
  input logic       memWrEn,
  input logic       wbFromMem,
  input logic [3:0] aluCode,
  input logic       jumpHit,
  input logic       brEqHit,
  input logic       brNeHit,
  input logic       illegalOp
);
  always_comb begin
    AST_RD_ONLY_RTYPE: assert (!rdSelect || opcodeIn == 6'h00); // R1
    AST_ZEXT_LOGIC: assert (!signExt || aluCode == 4'b0100 || aluCode == 4'b0101 || aluCode == 4'b0110); // R3
    AST_LOAD_PATH: assert (!memRdEn || (wbFromMem && regWrEn && immOperand && aluCode == 4'b0100)); // R4
    AST_MEM_EXCL: assert (!(memRdEn && memWrEn)); // R5
    AST_STORE_NO_WB: assert (!memWrEn || (!regWrEn && immOperand && aluCode == 4'b0100)); // R5
    AST_BRANCH_SUB: assert (!(brEqHit || brNeHit) || (aluCode == 4'b0101 && !regWrEn && !immOperand && !memRdEn && !memWrEn)); // R6
    AST_JUMP_QUIET: assert (!jumpHit || (!regWrEn && !memRdEn && !memWrEn && aluCode == 4'b0000)); // R7
    AST_ILLEGAL_QUIET: assert (!illegalOp || (!regWrEn && !memRdEn && !memWrEn && !wbFromMem && aluCode == 4'b0000)); // R8
    AST_FLOW_ONEHOT: assert ($onehot0({jumpHit, brEqHit, brNeHit, illegalOp})); // R9
  end
endmodule

bind instrCtlDecoder instrCtlChecker u_chk (
  .opcodeIn  (opcodeIn),
  .rdSelect  (rdSelect),
  .regWrEn   (regWrEn),
  .signExt   (signExt),
  .immOperand(immOperand),
  .memRdEn   (memRdEn),
  .memWrEn   (memWrEn),
  .wbFromMem (wbFromMem),
  .aluCode   (aluCode),
  .jumpHit   (jumpHit),
  .brEqHit   (brEqHit),
  .brNeHit   (brNeHit),
  .illegalOp (illegalOp)
);

// File: tb/instrCtlDecoder_tb.sv
`timescale 1ns/1ps
module instrCtlDecoder_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [5:0] opcodeIn, functIn;
  logic rdSelect, regWrEn, signExt, immOperand, memRdEn, memWrEn, wbFromMem;
  logic [3:0] aluCode;
  logic jumpHit, brEqHit, brNeHit, illegalOp;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  instrCtlDecoder u_dut (
    .opcodeIn(opcodeIn), .functIn(functIn),
    .rdSelect(rdSelect), .regWrEn(regWrEn), .signExt(signExt),
    .immOperand(immOperand), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .wbFromMem(wbFromMem), .aluCode(aluCode), .jumpHit(jumpHit),
    .brEqHit(brEqHit), .brNeHit(brNeHit), .illegalOp(illegalOp)
  );

  // expected vector: {rdSel,regWr,sExt,imm,mRd,mWr,wb,alu[3:0],jmp,beq,bne,ill}
  function automatic logic [14:0] mk(input logic rd, input logic rw, input logic se,
      input logic im, input logic mr, input logic mw, input logic wb,
      input logic [3:0] alu, input logic jp, input logic bq, input logic bn,
      input logic il);
    return {rd, rw, se, im, mr, mw, wb, alu, jp, bq, bn, il};
  endfunction

  function automatic logic [14:0] expectOf(input logic [5:0] op, input logic [5:0] fn);
    logic [14:0] bad;
    bad = mk(0,0,0,0,0,0,0,4'b0000,0,0,0,1);
    case (op)
      6'h00: case (fn)  // R1
        6'h20: return mk(1,1,0,0,0,0,0,4'b0100,0,0,0,0);
        6'h22: return mk(1,1,0,0,0,0,0,4'b0101,0,0,0,0);
        6'h24: return mk(1,1,0,0,0,0,0,4'b0001,0,0,0,0);
        6'h25: return mk(1,1,0,0,0,0,0,4'b0010,0,0,0,0);
        6'h26: return mk(1,1,0,0,0,0,0,4'b0011,0,0,0,0);
        6'h2A: return mk(1,1,0,0,0,0,0,4'b0110,0,0,0,0);
        default: return bad;  // R8
      endcase
      6'h08: return mk(0,1,1,1,0,0,0,4'b0100,0,0,0,0);  // R2 R3
      6'h0A: return mk(0,1,1,1,0,0,0,4'b0110,0,0,0,0);
      6'h0C: return mk(0,1,0,1,0,0,0,4'b0001,0,0,0,0);
      6'h0D: return mk(0,1,0,1,0,0,0,4'b0010,0,0,0,0);
      6'h0E: return mk(0,1,0,1,0,0,0,4'b0011,0,0,0,0);
      6'h23: return mk(0,1,1,1,1,0,1,4'b0100,0,0,0,0);  // R4
      6'h2B: return mk(0,0,1,1,0,1,0,4'b0100,0,0,0,0);  // R5
      6'h04: return mk(0,0,1,0,0,0,0,4'b0101,0,1,0,0);  // R6
      6'h05: return mk(0,0,1,0,0,0,0,4'b0101,0,0,1,0);  // R6
      6'h02: return mk(0,0,0,0,0,0,0,4'b0000,1,0,0,0);  // R7
      default: return bad;  // R8
    endcase
  endfunction

  function automatic string reqOf(input logic [5:0] op, input logic [5:0] fn);
    logic [14:0] e;
    e = expectOf(op, fn);
    if (e[0]) return "R8";
    case (op)
      6'h00: return "R1";
      6'h23: return "R4";
      6'h2B: return "R5";
      6'h04, 6'h05: return "R6";
      6'h02: return "R7";
      default: return "R2/R3";
    endcase
  endfunction

  task automatic applyAndCheck(input logic [5:0] op, input logic [5:0] fn, input string tag);
    logic [14:0] act, exp;
    @(negedge clk);
    opcodeIn = op;
    functIn = fn;
    #2;
    act = {rdSelect, regWrEn, signExt, immOperand, memRdEn, memWrEn, wbFromMem,
           aluCode, jumpHit, brEqHit, brNeHit, illegalOp};
    exp = expectOf(op, fn);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s op=%h fn=%h actual=%b expected=%b", tag, op, fn, act, exp);
    end
  endtask

  // reset state: both fields zero is not a supported encoding (R8)
  task automatic testReset();
    applyAndCheck(6'h00, 6'h00, "R8 reset");
  endtask

  // every function code under opcode 0 (R1, R8)
  task automatic testRtypeSweep();
    for (int f = 0; f < 64; f++) applyAndCheck(6'h00, f[5:0], reqOf(6'h00, f[5:0]));
  endtask

  // every opcode with several function fields: R2..R8, and funct ignored (R9)
  task automatic testOpcodeSweep();
    for (int o = 1; o < 64; o++) begin
      applyAndCheck(o[5:0], 6'h00, reqOf(o[5:0], 6'h00));
      applyAndCheck(o[5:0], 6'h20, "R9 funct ignored");
      applyAndCheck(o[5:0], 6'h3F, "R9 funct ignored");
    end
  endtask

  // boundaries: neighbours of valid codes (R8), flow exclusivity (R9)
  task automatic testCorners();
    applyAndCheck(6'h00, 6'h21, "R8 near add");
    applyAndCheck(6'h00, 6'h2B, "R8 near slt");
    applyAndCheck(6'h03, 6'h00, "R8 near jump");
    applyAndCheck(6'h2B, 6'h2A, "R5 store with slt funct");
    applyAndCheck(6'h23, 6'h22, "R4 load with sub funct");
    applyAndCheck(6'h02, 6'h20, "R7 jump with add funct");
  endtask

  initial begin
    opcodeIn = 6'h00;
    functIn = 6'h00;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    testReset();
    testRtypeSweep();
    testOpcodeSweep();
    testCorners();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule